// File: doc/BRIEF.md
# Booth-Recoded Floating Point Multiplier

This block multiplies two floating point numbers that arrive over a 16-bit data bus. Each operand is a word made of a sign bit, a biased exponent and a fraction with an implied leading one. The word is 32 bits wide in short precision and 64 bits wide in long precision. The caller streams in the first operand and then the second, most significant slice first. The block then spends a fixed, counted number of clocks forming the product. When the result is ready it raises a valid flag, and the caller reads the result back one 16-bit slice per read strobe.

The fraction product comes from a combinational array. The multiplier significand is recoded into radix-4 signed digits, so the array has about half as many partial-product rows as a plain shift-and-add array. A linear chain of 3:2 compressors reduces the rows to a carry-save pair. Negative rows are formed by inversion, and a separate correction vector supplies their +1 terms. One carry-propagate addition then turns the pair into a binary product.

The product is normalised with at most one right shift, and the exponents are added with the bias removed once. The fraction is rounded to the selected precision. The exponent is then checked, and saturated or flushed if it falls out of range. Short operands travel through the same long-width array, left-aligned, so both precisions share one set of hardware.

Top module: `booth_fmul`

## Requirements
- R1: Word layout: the sign is the most significant bit, followed by an 8-bit exponent with bias 127, followed by the fraction, with an implied leading one. The fraction is 23 bits in the 32-bit short word and 55 bits in the 64-bit long word. An exponent field of 0 encodes zero.
- R2: Loading: the first operand is taken first and the second operand after it. Each operand takes 2 beats in short precision or 4 beats in long precision, most significant slice first. `long_sel` is sampled on the first beat of the first operand. `in_valid` has no effect while a product is being computed or unloaded.
- R3: `res_valid` rises on the 3rd rising clock edge (CALC_CYCLES) after the edge that accepts the final operand beat, and it stays low before that edge.
- R4: While `res_valid` is high, `dout` holds the most significant unread 16-bit slice of the result and stays stable until `rd` is asserted. Each `rd` advances to the next slice. After 2 reads (short) or 4 reads (long), `res_valid` falls and the block accepts a new load. After reset, `res_valid` and `dout` are 0.
- R5: The significand product is exact for every pair of significands. It is formed with radix-4 signed-digit recoding of the multiplier, carry-save accumulation and a final carry-propagate addition.
- R6: The result sign is the exclusive OR of the operand signs, for every nonzero result.
- R7: The result exponent is the sum of the operand exponents minus 127. It is incremented by one when the significand product is 2 or greater, in which case the product is shifted right one place.
- R8: The fraction is rounded to nearest, with ties away from zero, on the first discarded bit. A carry out of rounding increments the exponent again.
- R9: A final exponent above 255 forces the result to the given sign, exponent 255 and an all-ones fraction.
- R10: A final exponent below 1, or an operand with a zero exponent field, forces the whole result word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand slice on `din` is valid this cycle |
| long_sel | input | 1 | 1 selects 64-bit precision; sampled on the first load beat |
| din | input | 16 | Operand slice, most significant first |
| rd | input | 1 | Read strobe; advances to the next result slice |
| res_valid | output | 1 | Result available for unloading |
| dout | output | 16 | Current result slice |

## Verification
The bench builds the block with its default parameters: 8-bit exponent, 23- and 55-bit fractions, a 16-bit bus and a 3-cycle compute window. With these defaults the full 56-by-56-bit array is exercised in both precisions, and the bench's wide integer model reproduces it directly. The compute window is short enough that the exact cycle in which `res_valid` rises can be checked every time. Directed operands sit exactly on the exponent limits 255/256 and 1/0 and produce a rounding tie in each precision. Seeded random operands in both precisions cover general significand patterns against the model.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_CALC = 2'd1,
    ST_OUT  = 2'd2
  } fmul_state_e;

endpackage

// File: rtl/fmul_booth_row.sv
// One radix-4 partial-product row: selects 0, +-X or +-2X from a 3-bit
// overlapping multiplier group. Negative rows are one's complement here;
// the +1 is supplied by the array's correction vector.
module fmul_booth_row #(
  parameter int MW = 56
) (
  input  logic [2:0]    grp,
  input  logic [MW-1:0] x,
  output logic [MW+1:0] pp,
  output logic          neg
);

  logic one, two;
  logic [MW+1:0] mag;

  always_comb begin
    one = 1'b0;
    two = 1'b0;
    neg = 1'b0;
    unique case (grp)
      3'b001, 3'b010: one = 1'b1;
      3'b011:         two = 1'b1;
      3'b100:         begin two = 1'b1; neg = 1'b1; end
      3'b101, 3'b110: begin one = 1'b1; neg = 1'b1; end
      default:        ;
    endcase
  end

  always_comb begin
    if (two)      mag = {1'b0, x, 1'b0};
    else if (one) mag = {2'b00, x};
    else          mag = '0;
    pp = neg ? ~mag : mag;
  end

endmodule

// File: rtl/fmul_booth_array.sv
// Radix-4 recoded multiplier array with a linear carry-save chain.
module fmul_booth_array #(
  parameter int MW = 56
) (
  input  logic [MW-1:0]   xa,
  input  logic [MW-1:0]   yb,
  output logic [2*MW-1:0] sum_v,
  output logic [2*MW-1:0] car_v
);

  localparam int PW = 2 * MW;
  localparam int ND = (MW + 2) / 2;
  localparam int YW = 2 * ND + 1;

  logic [YW-1:0]   y_ext;
  logic [ND-1:0]   neg_v;
  logic [PW-1:0]   row_v [ND];
  logic [PW-1:0]   s_v   [ND];
  logic [PW-1:0]   c_v   [ND];
  logic [PW-1:0]   corr;

  assign y_ext = {{(YW-MW-1){1'b0}}, yb, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_row
    logic [MW+1:0] pp;
    logic [PW-1:0] ext;
    fmul_booth_row #(.MW(MW)) u_row (
      .grp (y_ext[2*i+2 -: 3]),
      .x   (xa),
      .pp  (pp),
      .neg (neg_v[i])
    );
    assign ext      = {{(PW-MW-2){pp[MW+1]}}, pp};
    assign row_v[i] = ext << (2 * i);
  end

  // sign correction: the +1 of each negated row, at that row's weight
  always_comb begin
    corr = '0;
    for (int i = 0; i < ND; i++) corr[2*i] = neg_v[i];
  end

  assign s_v[0] = row_v[0];
  assign c_v[0] = corr;

  for (genvar i = 1; i < ND; i++) begin : g_csa
    logic [PW-1:0] maj;
    assign s_v[i] = s_v[i-1] ^ c_v[i-1] ^ row_v[i];
    assign maj    = (s_v[i-1] & c_v[i-1]) | (s_v[i-1] & row_v[i]) |
                    (c_v[i-1] & row_v[i]);
    assign c_v[i] = maj << 1;
  end

  assign sum_v = s_v[ND-1];
  assign car_v = c_v[ND-1];

endmodule

// File: rtl/fmul_round_pack.sv
// Normalise, round (nearest, ties away), add exponents, saturate/flush, pack.
// The short result is returned left-aligned in the long word.
module fmul_round_pack #(
  parameter int EXP_W      = 8,
  parameter int SHORT_FRAC = 23,
  parameter int LONG_FRAC  = 55
) (
  input  logic [LONG_FRAC+2:0]       prod_hi,
  input  logic [EXP_W-1:0]           ea,
  input  logic [EXP_W-1:0]           eb,
  input  logic                       sgn,
  input  logic                       zero_in,
  input  logic                       lng,
  output logic [LONG_FRAC+EXP_W:0]   res,
  output logic                       ovf,
  output logic                       unf
);

  localparam int LONG_W  = 1 + EXP_W + LONG_FRAC;
  localparam int SHORT_W = 1 + EXP_W + SHORT_FRAC;
  localparam int PAD     = LONG_W - SHORT_W;
  localparam int QW      = LONG_FRAC + 2;
  localparam int XW      = EXP_W + 3;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int MAXE    = (1 << EXP_W) - 1;

  logic                  norm, carry;
  logic [QW-1:0]         q;
  logic [LONG_FRAC+1:0]  rs_l;
  logic [SHORT_FRAC+1:0] rs_s;
  logic signed [XW-1:0]  e_fin;

  assign norm = prod_hi[QW];
  assign q    = norm ? prod_hi[QW:1] : prod_hi[QW-1:0];

  assign rs_l  = {1'b0, q[QW-1 -: LONG_FRAC+1]}  + {{(LONG_FRAC+1){1'b0}}, q[QW-LONG_FRAC-2]};
  assign rs_s  = {1'b0, q[QW-1 -: SHORT_FRAC+1]} + {{(SHORT_FRAC+1){1'b0}}, q[QW-SHORT_FRAC-2]};
  assign carry = lng ? rs_l[LONG_FRAC+1] : rs_s[SHORT_FRAC+1];

  assign e_fin = signed'(XW'(ea) + XW'(eb) + XW'(norm) + XW'(carry) - XW'(BIAS));

  assign ovf = !zero_in && (e_fin > signed'(XW'(MAXE)));
  assign unf = !zero_in && (e_fin < signed'(XW'(1)));

  always_comb begin
    if (zero_in || unf) begin
      res = '0;
    end else if (ovf) begin
      if (lng) res = {sgn, {EXP_W{1'b1}}, {LONG_FRAC{1'b1}}};
      else     res = {sgn, {EXP_W{1'b1}}, {SHORT_FRAC{1'b1}}, {PAD{1'b0}}};
    end else begin
      if (lng) res = {sgn, e_fin[EXP_W-1:0], rs_l[LONG_FRAC-1:0]};
      else     res = {sgn, e_fin[EXP_W-1:0], rs_s[SHORT_FRAC-1:0], {PAD{1'b0}}};
    end
  end

endmodule

// File: rtl/booth_fmul.sv
module booth_fmul
  import fmul_pkg::*;
#(
  parameter int EXP_W       = 8,
  parameter int SHORT_FRAC  = 23,
  parameter int LONG_FRAC   = 55,
  parameter int BUS_W       = 16,
  parameter int CALC_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             long_sel,
  input  logic [BUS_W-1:0] din,
  input  logic             rd,
  output logic             res_valid,
  output logic [BUS_W-1:0] dout
);

  localparam int LONG_W      = 1 + EXP_W + LONG_FRAC;
  localparam int SHORT_W     = 1 + EXP_W + SHORT_FRAC;
  localparam int MW          = LONG_FRAC + 1;
  localparam int PW          = 2 * MW;
  localparam int LONG_BEATS  = LONG_W / BUS_W;
  localparam int SHORT_BEATS = SHORT_W / BUS_W;
  localparam int BCW         = $clog2(2 * LONG_BEATS + 1);
  localparam int CCW         = $clog2(CALC_CYCLES + 1);
  localparam int FPAD        = LONG_FRAC - SHORT_FRAC;

  fmul_state_e      st;
  logic [BCW-1:0]   bcnt;
  logic [CCW-1:0]   ccnt;
  logic             lng_q;
  logic [LONG_W-1:0] opa, opb, out_sh, rp_word;
  logic [BCW-1:0]   per_now, per_q;

  // ---------------- operand field extraction ----------------
  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [MW-1:0]    man_a, man_b;

  always_comb begin
    if (lng_q) begin
      sa = opa[LONG_W-1];  ea = opa[LONG_W-2 -: EXP_W];
      sb = opb[LONG_W-1];  eb = opb[LONG_W-2 -: EXP_W];
      man_a = {1'b1, opa[LONG_FRAC-1:0]};
      man_b = {1'b1, opb[LONG_FRAC-1:0]};
    end else begin
      sa = opa[SHORT_W-1]; ea = opa[SHORT_W-2 -: EXP_W];
      sb = opb[SHORT_W-1]; eb = opb[SHORT_W-2 -: EXP_W];
      man_a = {1'b1, opa[SHORT_FRAC-1:0], {FPAD{1'b0}}};
      man_b = {1'b1, opb[SHORT_FRAC-1:0], {FPAD{1'b0}}};
    end
  end

  // ---------------- datapath ----------------
  logic [PW-1:0] sum_v, car_v, prod;
  logic          rp_ovf, rp_unf, zero_in;

  fmul_booth_array #(.MW(MW)) u_array (
    .xa    (man_a),
    .yb    (man_b),
    .sum_v (sum_v),
    .car_v (car_v)
  );

  assign prod    = sum_v + car_v;   // carry-propagate conversion
  assign zero_in = (ea == '0) || (eb == '0);

  fmul_round_pack #(
    .EXP_W(EXP_W), .SHORT_FRAC(SHORT_FRAC), .LONG_FRAC(LONG_FRAC)
  ) u_round (
    .prod_hi (prod[PW-1 -: LONG_FRAC+3]),
    .ea      (ea),
    .eb      (eb),
    .sgn     (sa ^ sb),
    .zero_in (zero_in),
    .lng     (lng_q),
    .res     (rp_word),
    .ovf     (rp_ovf),
    .unf     (rp_unf)
  );

  // ---------------- bus sequencing ----------------
  assign per_now = (bcnt == '0 ? long_sel : lng_q) ? BCW'(LONG_BEATS) : BCW'(SHORT_BEATS);
  assign per_q   = lng_q ? BCW'(LONG_BEATS) : BCW'(SHORT_BEATS);
  assign dout    = out_sh[LONG_W-1 -: BUS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_LOAD;
      bcnt      <= '0;
      ccnt      <= '0;
      lng_q     <= 1'b0;
      opa       <= '0;
      opb       <= '0;
      out_sh    <= '0;
      res_valid <= 1'b0;
    end else begin
      unique case (st)
        ST_LOAD: if (in_valid) begin
          if (bcnt == '0) lng_q <= long_sel;
          if (bcnt < per_now) begin
            opa <= (bcnt == '0) ? LONG_W'(din) : {opa[LONG_W-BUS_W-1:0], din};
          end else begin
            opb <= (bcnt == per_now) ? LONG_W'(din) : {opb[LONG_W-BUS_W-1:0], din};
          end
          if (bcnt == 2 * per_now - 1) begin
            st   <= ST_CALC;
            bcnt <= '0;
            ccnt <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_CALC: begin
          if (ccnt == CCW'(CALC_CYCLES - 1)) begin
            out_sh    <= rp_word;
            res_valid <= 1'b1;
            st        <= ST_OUT;
          end else begin
            ccnt <= ccnt + 1'b1;
          end
        end
        ST_OUT: if (rd) begin
          out_sh <= out_sh << BUS_W;
          if (bcnt == per_q - 1) begin
            st        <= ST_LOAD;
            res_valid <= 1'b0;
            bcnt      <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R5: carry-save array plus final addition equals the integer product
  a_r5_array_product: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC) |-> (prod == (PW'(man_a) * PW'(man_b))));

  // R2: operands are frozen while the product is formed
  a_r2_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC) |=> ($stable(opa) && $stable(opb)));

  // R3: the valid flag only rises at the end of the compute window
  a_r3_valid_after_calc: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> ($past(st) == ST_CALC));

  // R4: output slice held while not read
  a_r4_dout_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !rd) |=> $stable(dout));

  // R6: sign of a nonzero result follows the operand signs
  a_r6_sign: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC && rp_word != '0) |-> (rp_word[LONG_W-1] == (sa ^ sb)));

  // R9: saturation forces an all-ones exponent field
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC && rp_ovf) |-> (rp_word[LONG_W-2 -: EXP_W] == '1));

  // R10: flush produces an all-zero word
  a_r10_flush_zero: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALC && (rp_unf || zero_in)) |-> (rp_word == '0));

endmodule

// File: tb/test_booth_fmul.sv
module test_booth_fmul;

  localparam int CALC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        long_sel = 1'b0;
  logic [15:0] din = '0;
  logic        rd = 1'b0;
  logic        res_valid;
  logic [15:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  booth_fmul #(.CALC_CYCLES(CALC)) i_booth_fmul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .long_sel(long_sel),
    .din(din), .rd(rd), .res_valid(res_valid), .dout(dout)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model from the requirements (R1, R5..R10)
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b, input bit lng);
    int f = lng ? 55 : 23;
    logic [111:0] ma, mb, p, keep, rs;
    int ea, eb, e;
    logic s, nrm, rb, cy;
    if (lng) begin
      s = a[63] ^ b[63]; ea = int'(a[62:55]); eb = int'(b[62:55]);
      ma = {57'b0, 1'b1, a[54:0]}; mb = {57'b0, 1'b1, b[54:0]};
    end else begin
      s = a[31] ^ b[31]; ea = int'(a[30:23]); eb = int'(b[30:23]);
      ma = {88'b0, 1'b1, a[22:0]}; mb = {88'b0, 1'b1, b[22:0]};
    end
    if (ea == 0 || eb == 0) return 64'b0;
    p   = ma * mb;
    nrm = p[2*f+1];
    if (nrm) begin keep = p >> (f + 1); rb = p[f]; end
    else     begin keep = p >> f;       rb = p[f-1]; end
    rs = keep + {111'b0, rb};
    cy = rs[f+1];
    if (cy) rs = rs >> 1;
    e = ea + eb - 127 + int'(nrm) + int'(cy);
    if (e > 255) return lng ? {s, 8'hFF, {55{1'b1}}} : {32'b0, s, 8'hFF, {23{1'b1}}};
    if (e < 1)   return 64'b0;
    return lng ? {s, 8'(e), rs[54:0]} : {32'b0, s, 8'(e), rs[22:0]};
  endfunction

  // full load / compute / unload sequence
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit lng,
                        input bit timing, input bit inject, output logic [63:0] res);
    int n = lng ? 4 : 2;
    for (int j = 0; j < n; j++) begin
      @(negedge clk); in_valid = 1'b1; long_sel = lng; din = a[16*(n-1-j) +: 16];
    end
    for (int j = 0; j < n; j++) begin
      @(negedge clk); in_valid = 1'b1; long_sel = ~lng; din = b[16*(n-1-j) +: 16];
    end
    @(negedge clk); in_valid = 1'b0; long_sel = 1'b0;
    repeat (CALC - 1) @(negedge clk);
    if (timing) chk("R3 valid low before window end", 64'(res_valid), 64'd0);
    @(negedge clk);
    if (timing) chk("R3 valid at window end", 64'(res_valid), 64'd1);
    while (!res_valid) @(negedge clk);
    if (inject) begin
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; din = 16'hFFFF; long_sel = ~lng; @(negedge clk);
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R4 dout stable without rd", 64'(dout), lng ? 64'(res_hi16(a, b, lng)) : 64'(res_hi16(a, b, lng)));
    end
    res = '0;
    for (int j = 0; j < n; j++) begin
      res = {res[47:0], dout};
      rd = 1'b1;
      @(negedge clk);
    end
    rd = 1'b0;
    chk("R4 valid drops after last read", 64'(res_valid), 64'd0);
  endtask

  function automatic logic [15:0] res_hi16(input logic [63:0] a, input logic [63:0] b, input bit lng);
    logic [63:0] m = model(a, b, lng);
    return lng ? m[63:48] : m[31:16];
  endfunction

  task automatic do_short(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp);
    logic [63:0] r;
    run_op({32'b0, a}, {32'b0, b}, 1'b0, 1'b0, 1'b0, r);
    chk(tag, r, {32'b0, exp});
  endtask

  task automatic do_long(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] exp);
    logic [63:0] r;
    run_op(a, b, 1'b1, 1'b0, 1'b0, r);
    chk(tag, r, exp);
  endtask

  task automatic t_reset();
    chk("R4 reset res_valid", 64'(res_valid), 64'd0);
    chk("R4 reset dout", 64'(dout), 64'd0);
  endtask

  task automatic t_format();
    do_short("R1 short 1.0*1.0", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000);
    do_long ("R1 long 2.0*3.0", 64'h4000_0000_0000_0000, 64'h4040_0000_0000_0000,
             64'h40C0_0000_0000_0000);
  endtask

  task automatic t_timing();
    logic [63:0] r;
    run_op(64'h3FC0_0000, 64'h4000_0000, 1'b0, 1'b1, 1'b0, r);
    chk("R3 timed short result", r, 64'h4040_0000);
    run_op(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, 1'b1, 1'b0, r);
    chk("R3 timed long result", r, model(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1));
  endtask

  task automatic t_ignore();
    logic [63:0] r;
    run_op(64'h4010_0000, 64'h3FA0_0000, 1'b0, 1'b0, 1'b1, r);
    chk("R2 in_valid ignored during unload", r, model(64'h4010_0000, 64'h3FA0_0000, 1'b0));
    do_short("R2 next load after ignored beats", 32'h4040_0000, 32'h4040_0000, 32'h4110_0000);
  endtask

  task automatic t_sign();
    do_short("R6 neg*pos", 32'hBFC0_0000, 32'h4000_0000, 32'hC040_0000);
    do_long ("R6 neg*neg", 64'hC000_0000_0000_0000, 64'hC040_0000_0000_0000,
             64'h40C0_0000_0000_0000);
  endtask

  task automatic t_norm();
    do_short("R7 1.5*1.5 renormalises", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000);
  endtask

  task automatic t_round();
    do_short("R8 short tie rounds away", 32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002);
    do_long ("R8 long tie rounds away", 64'h3F80_0000_0000_0001, 64'h3FC0_0000_0000_0000,
             64'h3FC0_0000_0000_0002);
    do_short("R8 all-ones significands", 32'h3FFF_FFFF, 32'h3FFF_FFFF,
             model(64'h3FFF_FFFF, 64'h3FFF_FFFF, 1'b0)[31:0]);
  endtask

  task automatic t_overflow();
    do_short("R9 overflow positive", 32'h7800_0000, 32'h7800_0000, 32'h7FFF_FFFF);
    do_short("R9 overflow negative", 32'hF800_0000, 32'h7800_0000, 32'hFFFF_FFFF);
    do_short("R9 exponent exactly 255", 32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000);
    do_short("R9 normalisation pushes to 256", 32'h7FC0_0000, 32'h3FC0_0000, 32'h7FFF_FFFF);
    do_long ("R9 long overflow", 64'h7800_0000_0000_0000, 64'h7800_0000_0000_0000,
             64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_underflow();
    do_short("R10 exponent exactly 1", 32'h0080_0000, 32'h3F80_0000, 32'h0080_0000);
    do_short("R10 exponent 0 flushes", 32'h0080_0000, 32'h3F00_0000, 32'h0000_0000);
    do_short("R10 zero operand", 32'h0000_0000, 32'h4040_0000, 32'h0000_0000);
    do_long ("R10 negative zero operand", 64'hC040_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 12; k++) begin
      logic [31:0] a = $urandom, b = $urandom;
      a[30:23] = 8'(100 + ($urandom % 55));
      b[30:23] = 8'(100 + ($urandom % 55));
      do_short("R5 random short", a, b, model({32'b0, a}, {32'b0, b}, 1'b0)[31:0]);
    end
    for (int k = 0; k < 12; k++) begin
      logic [63:0] a = {$urandom, $urandom}, b = {$urandom, $urandom};
      a[62:55] = 8'(100 + ($urandom % 55));
      b[62:55] = 8'(100 + ($urandom % 55));
      do_long("R5 random long", a, b, model(a, b, 1'b1));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_format();
    t_timing();
    t_ignore();
    t_sign();
    t_norm();
    t_round();
    t_overflow();
    t_underflow();
    t_random();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule